// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the level-sensitive INTA..INTD lines of the devices on a PCI bus and drives a set of legacy interrupt-controller inputs. Each device pin first passes through a slot-based rotation onto one of four shared interrupt lines, called link lines here. Four byte-wide routing registers then steer every link line to one controller input, or turn it off. Several link lines may land on one input; that input is the OR of all of them.

Levels are kept in a bitmap with one bit per pair of output and link line. When software rewrites a routing register, the block clears the bitmap. It then fills it again from the current link levels, one link line per cycle, through the new routing, and only then publishes new outputs. Input changes that arrive during this rebuild wait and take effect once it ends. Inputs are synchronised to the block clock and the outputs are registered.

Top module: `intx_router`

## Requirements
- R1: After reset every routing register reads 0x80 and every bit of irq_o is 0.
- R2: Input bit d*4+p is pin p (0=INTA..3=INTD) of device index d, which sits in slot FIRST_SLOT+d. It drives link line (p + slot - 1) mod 4, where link 0..3 are A..D.
- R3: The routing register of link k is at address ROUTE_BASE+k (0x60..0x63 by default) and reads back the full written byte. Other addresses read 0, and writes to them change neither any register nor irq_o.
- R4: A routing value below NUM_OUT (16) sends its link line to output value[3:0]. A value of 16 or above (including 0x10..0x7F and any value with bit 7 set) disables the link, and that link then asserts no output.
- R5: Each output is high when at least one enabled link line routed to it is high, so link lines can share an output.
- R6: With routing idle, a change on intx_i shows on irq_o at the fourth rising clock edge after it is applied, and not before.
- R7: A write to a routing register starts a rebuild. irq_o holds its old value through the write edge and the following four edges, and it takes the value for the new routing at the fifth edge after the write.
- R8: Input changes made during a rebuild are not lost. irq_o reflects them once the rebuild has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intx_i | input | NUM_DEV*4 | Device interrupt pins, level high, bit d*4+p |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i, combinational |
| irq_o | output | NUM_OUT | Interrupt-controller inputs, registered |

## Verification
The assertions assume that a configuration write is a single-cycle strobe with its address stable in that cycle. They also assume that interrupt pins are plain levels, whose changes may come at any time relative to writes. The bench drives pins and strobes only on falling edges and keeps each write to one cycle. It does change pins inside a rebuild window, on purpose, so that the hold and deferral rules are exercised. Every expected output is derived from a model of the routing bytes and the pin vector, computed only after the bench has waited out the synchronisation and rebuild latency.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
  localparam int NUM_PIRQ = 4;
  localparam int PINS_PER_DEV = 4;
  localparam int PIRQ_W = $clog2(NUM_PIRQ);

  typedef logic [7:0] route_t;
  typedef enum logic {TRK_IDLE, TRK_REBUILD} trk_state_e;

  // (slot - 1) mod 4 written as (slot + 3) to stay non-negative for slot 0
  function automatic logic [PIRQ_W-1:0] swizzle(input int unsigned slot, input int unsigned pin);
    return PIRQ_W'((pin + slot + NUM_PIRQ - 1) % NUM_PIRQ);
  endfunction
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import intx_router_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int FIRST_SLOT = 1,
  localparam int IN_W      = NUM_DEV * PINS_PER_DEV
) (
  input  logic [IN_W-1:0]     intx_i,
  output logic [NUM_PIRQ-1:0] lvl_o
);
  logic [NUM_DEV-1:0][NUM_PIRQ-1:0] dev_lvl;

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      always_comb begin
        dev_lvl[d] = '0;
        for (int p = 0; p < PINS_PER_DEV; p++) begin
          if (intx_i[d*PINS_PER_DEV+p])
            dev_lvl[d][swizzle(FIRST_SLOT + d, p)] = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    lvl_o = '0;
    for (int d = 0; d < NUM_DEV; d++) lvl_o |= dev_lvl[d];
  end
endmodule

// File: rtl/route_regs.sv
module route_regs
  import intx_router_pkg::*;
#(
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  parameter logic [7:0] ROUTE_RESET = 8'h80
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [7:0]                   wdata_i,
  output logic [7:0]                   rdata_o,
  output logic [NUM_PIRQ-1:0][7:0]     route_o,
  output logic                         upd_o
);
  localparam int LAST = int'(ROUTE_BASE) + NUM_PIRQ - 1;

  logic              hit;
  logic [PIRQ_W-1:0] idx;
  logic [7:0]        off;

  assign off = addr_i - ROUTE_BASE;
  assign hit = (int'(addr_i) >= int'(ROUTE_BASE)) && (int'(addr_i) <= LAST);
  assign idx = off[PIRQ_W-1:0];

  generate
    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          route_o[k] <= ROUTE_RESET;
        else if (we_i && hit && idx == PIRQ_W'(k)) route_o[k] <= wdata_i;
      end
    end
  endgenerate

  assign upd_o   = we_i && hit;
  assign rdata_o = hit ? route_o[idx] : 8'h00;
endmodule

// File: rtl/level_tracker.sv
module level_tracker
  import intx_router_pkg::*;
#(
  parameter int NUM_OUT = 16,
  localparam int MAP_W  = NUM_OUT * NUM_PIRQ,
  localparam int SEL_W  = $clog2(NUM_OUT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PIRQ-1:0]      lvl_i,
  input  logic [NUM_PIRQ-1:0][7:0] route_i,
  input  logic                     start_i,
  output logic [NUM_OUT-1:0]       irq_o,
  output logic                     busy_o,
  output logic [MAP_W-1:0]         map_o
);
  trk_state_e            state_q;
  logic [PIRQ_W-1:0]     step_q;
  logic [NUM_PIRQ-1:0]   snap_q;
  logic [MAP_W-1:0]      map_q;
  logic [NUM_OUT-1:0]    grp_or;
  logic [NUM_PIRQ-1:0]   en;
  logic [NUM_PIRQ-1:0][SEL_W-1:0] sel;

  generate
    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_dec
      assign en[k]  = int'(route_i[k]) < NUM_OUT;
      assign sel[k] = route_i[k][SEL_W-1:0];
    end
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_or
      assign grp_or[o] = |map_q[o*NUM_PIRQ +: NUM_PIRQ];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      step_q  <= '0;
      snap_q  <= '0;
      map_q   <= '0;
    end else if (start_i) begin
      // any routing write restarts the rebuild from an empty map
      state_q <= TRK_REBUILD;
      step_q  <= '0;
      snap_q  <= lvl_i;
      map_q   <= '0;
    end else if (state_q == TRK_REBUILD) begin
      if (en[step_q])
        map_q[int'(sel[step_q]) * NUM_PIRQ + int'(step_q)] <= snap_q[step_q];
      step_q <= step_q + 1'b1;
      if (step_q == PIRQ_W'(NUM_PIRQ - 1)) state_q <= TRK_IDLE;
    end else begin
      for (int k = 0; k < NUM_PIRQ; k++) begin
        if (en[k]) map_q[int'(sel[k]) * NUM_PIRQ + k] <= lvl_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    irq_o <= '0;
    else if (state_q == TRK_IDLE)   irq_o <= grp_or;
  end

  assign busy_o = (state_q == TRK_REBUILD);
  assign map_o  = map_q;
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_router_pkg::*;
#(
  parameter int         NUM_DEV     = 4,
  parameter int         FIRST_SLOT  = 1,
  parameter int         NUM_OUT     = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ROUTE_BASE  = 8'h60,
  localparam int        IN_W        = NUM_DEV * PINS_PER_DEV,
  localparam int        MAP_W       = NUM_OUT * NUM_PIRQ
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IN_W-1:0]    intx_i,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_addr_i,
  input  logic [7:0]         cfg_wdata_i,
  output logic [7:0]         cfg_rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [IN_W-1:0]          intx_s;
  logic [NUM_PIRQ-1:0]      pirq_lvl;
  logic [NUM_PIRQ-1:0][7:0] route;
  logic                     route_upd;
  logic                     rebuild_busy;
  logic [MAP_W-1:0]         level_map;

  intx_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (intx_i),
    .q_o   (intx_s)
  );

  pirq_swizzle #(.NUM_DEV(NUM_DEV), .FIRST_SLOT(FIRST_SLOT)) u_swz (
    .intx_i(intx_s),
    .lvl_o (pirq_lvl)
  );

  route_regs #(.ROUTE_BASE(ROUTE_BASE), .ROUTE_RESET(8'h80)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .route_o(route),
    .upd_o  (route_upd)
  );

  level_tracker #(.NUM_OUT(NUM_OUT)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pirq_lvl),
    .route_i(route),
    .start_i(route_upd),
    .irq_o  (irq_o),
    .busy_o (rebuild_busy),
    .map_o  (level_map)
  );
endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk
  import intx_router_pkg::*;
#(
  parameter int         NUM_OUT    = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60,
  localparam int        MAP_W      = NUM_OUT * NUM_PIRQ
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic [7:0]               cfg_addr_i,
  input logic [7:0]               cfg_rdata_o,
  input logic [NUM_OUT-1:0]       irq_o,
  input logic [NUM_PIRQ-1:0][7:0] route,
  input logic                     rebuild_busy,
  input logic [MAP_W-1:0]         level_map
);
  logic in_win;
  logic all_off;

  assign in_win = (int'(cfg_addr_i) >= int'(ROUTE_BASE)) &&
                  (int'(cfg_addr_i) < int'(ROUTE_BASE) + NUM_PIRQ);

  always_comb begin
    all_off = 1'b1;
    for (int k = 0; k < NUM_PIRQ; k++)
      if (int'(route[k]) < NUM_OUT) all_off = 1'b0;
  end

  p_outside_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> cfg_rdata_o == 8'h00);

  p_disabled_leaves_map_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_off && !rebuild_busy) |-> level_map == '0);

  p_one_bit_per_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(level_map) <= NUM_PIRQ);

  p_write_starts_rebuild_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && in_win) |=> rebuild_busy);

  p_hold_in_rebuild_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rebuild_busy |=> $stable(irq_o));
endmodule

bind intx_router intx_router_chk #(.NUM_OUT(NUM_OUT), .ROUTE_BASE(ROUTE_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .irq_o       (irq_o),
  .route       (route),
  .rebuild_busy(rebuild_busy),
  .level_map   (level_map)
);

// File: tb/intx_router_test.sv
module intx_router_test;
  localparam int NUM_DEV = 4;
  localparam int FIRST_SLOT = 1;
  localparam int NUM_OUT = 16;
  localparam int IN_W = NUM_DEV * 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [IN_W-1:0]   intx_i = '0;
  logic              cfg_we_i = 1'b0;
  logic [7:0]        cfg_addr_i = 8'h00;
  logic [7:0]        cfg_wdata_i = 8'h00;
  logic [7:0]        cfg_rdata_o;
  logic [NUM_OUT-1:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl_route [4];

  always #10 clk_i = ~clk_i;

  intx_router #(.NUM_DEV(NUM_DEV), .FIRST_SLOT(FIRST_SLOT), .NUM_OUT(NUM_OUT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .intx_i(intx_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_OUT-1:0] exp_irq(input logic [IN_W-1:0] v);
    logic [NUM_OUT-1:0] r = '0;
    for (int d = 0; d < NUM_DEV; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p]) begin
          int q = (p + FIRST_SLOT + d + 3) % 4;
          if (mdl_route[q] < 8'd16) r[mdl_route[q][3:0]] = 1'b1;
        end
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    if (a >= 8'h60 && a <= 8'h63) mdl_route[a - 8'h60] = d;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic [NUM_OUT-1:0] old_v;
    for (int k = 0; k < 4; k++) mdl_route[k] = 8'h80;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset values
    for (int k = 0; k < 4; k++) begin
      rd(8'h60 + 8'(k), rv);
      chk("R1 route reset", 32'(rv), 32'h80);
    end
    chk("R1 irq reset", 32'(irq_o), 32'h0);

    // R3 read-back and outside addresses
    for (int k = 0; k < 4; k++) begin
      wr(8'h60 + 8'(k), 8'h5A ^ 8'(k * 17));
      rd(8'h60 + 8'(k), rv);
      chk("R3 readback", 32'(rv), 32'(8'h5A ^ 8'(k * 17)));
    end
    foreach (mdl_route[k]) begin
      wr(8'h60 + 8'(k), 8'h80);
    end
    intx_i = '1;
    settle();
    wr(8'h5F, 8'h01);
    wr(8'h64, 8'h02);
    settle();
    rd(8'h5F, rv); chk("R3 outside read 5F", 32'(rv), 32'h0);
    rd(8'h64, rv); chk("R3 outside read 64", 32'(rv), 32'h0);
    rd(8'h60, rv); chk("R3 no side write", 32'(rv), 32'h80);
    chk("R3 no effect on irq", 32'(irq_o), 32'h0);
    intx_i = '0;
    settle();

    // R2 swizzle sweep with distinct routes
    wr(8'h60, 8'd1); wr(8'h61, 8'd2); wr(8'h62, 8'd3); wr(8'h63, 8'd4);
    settle();
    for (int d = 0; d < NUM_DEV; d++)
      for (int p = 0; p < 4; p++) begin
        intx_i = '0; intx_i[d*4+p] = 1'b1;
        settle();
        chk("R2 swizzle", 32'(irq_o),
            32'(1 << mdl_route[(p + FIRST_SLOT + d + 3) % 4]));
        intx_i = '0;
        settle();
      end

    // R6 exact latency
    @(negedge clk_i) intx_i = 16'h0001;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) chk("R6 not before 4th edge", 32'(irq_o), 32'h0);
    @(posedge clk_i);
    @(negedge clk_i) chk("R6 at 4th edge", 32'(irq_o), 32'(exp_irq(16'h0001)));
    intx_i = '0;
    settle();

    // R5 sharing sweeps
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 0) begin
        for (int k = 0; k < 4; k++) wr(8'h60 + 8'(k), 8'd5);
      end else begin
        wr(8'h60, 8'd7); wr(8'h61, 8'd7); wr(8'h62, 8'd9); wr(8'h63, 8'd12);
      end
      for (int v = 0; v < 256; v++) begin
        @(negedge clk_i) intx_i = 16'(v * 257) ^ 16'(v << 3);
        repeat (6) @(posedge clk_i);
        @(negedge clk_i) chk("R5 shared or", 32'(irq_o), 32'(exp_irq(intx_i)));
      end
    end
    intx_i = '0;

    // R4 disable values and edge selectors
    for (int k = 1; k < 4; k++) wr(8'h60 + 8'(k), 8'h80);
    intx_i = '1;
    foreach (mdl_route[i]) if (i == 0) begin end
    wr(8'h60, 8'h10); settle(); chk("R4 0x10 disabled", 32'(irq_o), 32'h0);
    wr(8'h60, 8'h7F); settle(); chk("R4 0x7F disabled", 32'(irq_o), 32'h0);
    wr(8'h60, 8'hFF); settle(); chk("R4 0xFF disabled", 32'(irq_o), 32'h0);
    wr(8'h60, 8'h8F); settle(); chk("R4 bit7 disabled", 32'(irq_o), 32'h0);
    wr(8'h60, 8'h0F); settle(); chk("R4 output 15", 32'(irq_o), 32'h8000);
    wr(8'h60, 8'h00); settle(); chk("R4 output 0", 32'(irq_o), 32'h0001);

    // R7 rebuild hold and exact update
    old_v = irq_o;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'h60; cfg_wdata_i = 8'd6; mdl_route[0] = 8'd6;
    @(posedge clk_i);
    @(negedge clk_i) cfg_we_i = 1'b0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i) chk("R7 hold 4 edges", 32'(irq_o), 32'(old_v));
    @(posedge clk_i);
    @(negedge clk_i) chk("R7 new at 5th edge", 32'(irq_o), 32'(exp_irq(intx_i)));

    // R8 input changes during rebuild
    wr(8'h61, 8'd3); wr(8'h62, 8'd10); wr(8'h63, 8'd11);
    intx_i = '0;
    settle();
    chk("R8 baseline", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'h61; cfg_wdata_i = 8'd13; mdl_route[1] = 8'd13;
    @(posedge clk_i);
    @(negedge clk_i) begin cfg_we_i = 1'b0; intx_i = 16'h00F0; end
    @(posedge clk_i);
    @(negedge clk_i) intx_i = 16'h0F0F;
    settle();
    chk("R8 deferred change applied", 32'(irq_o), 32'(exp_irq(16'h0F0F)));
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'h63; cfg_wdata_i = 8'h90; mdl_route[3] = 8'h90;
    @(posedge clk_i);
    @(negedge clk_i) begin cfg_we_i = 1'b0; intx_i = 16'h1111; end
    settle();
    chk("R8 change in rebuild with disable", 32'(irq_o), 32'(exp_irq(16'h1111)));

    summary();
    $finish;
  end
endmodule